// File: doc/BRIEF.md
# Eight-Input Interrupt Controller Programming Port

This block is the byte-wide programming port of an eight-input interrupt controller, together with the priority resolver it drives. Software writes command bytes to one of two addresses. An initialization byte starts a short sequence of follow-up words. These words set the vector base, pass over the cascade word, and optionally configure the mode. Once initialized, the port accepts operational commands: mask loads, end-of-interrupt variants, priority rotation, register-read selection, special mask mode and polling.

The resolver works on three registers: the edge-captured pending register, the mask register and the in-service register. It uses a rotating priority base, so the input at the base has the highest priority. It raises a request line when an unmasked pending input outranks everything in service. An acknowledge strobe returns the vector and moves the winner into service. A poll read returns the same information through the data port.

Top module: `pic_prog_port`

## Requirements
- R1: After reset, the pending, in-service and mask registers are zero, the priority base is 0, the sequence is idle, reads return the pending register, and `int_req`, `level_err` and `nested_mode` are 0.
- R2: A rising edge on `irq_in[i]` sets pending bit i one clock later; a level held high does not set the bit again after it has been cleared.
- R3: The rank of input i is (i - base) mod 8, where lower is higher priority. `int_req` is 1 when the best unmasked pending input has a lower rank than every in-service input; in special mask mode, in-service inputs that are masked are left out of this comparison.
- R4: A write to address 0 with bit 4 set clears the following: the pending, in-service and mask registers, the base, the read select, the poll flag, special mask, auto-EOI, rotate-on-auto-EOI and the nested flag. It stores bit 0 as "mode word needed" and bit 1 as "single". It sets `level_err` to bit 3 and does not use that bit otherwise. It then waits for the vector-base word.
- R5: In the vector-base state, an address-1 write stores the data with bits 2:0 forced to zero. The sequence then goes to the cascade state when single is 0, to the mode state when single is 1 and a mode word is needed, and otherwise to idle. A write in the cascade state goes to the mode state if needed, and otherwise to idle.
- R6: A write in the mode state sets `nested_mode` from bit 4 and auto-EOI from bit 1, then returns to idle.
- R7: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a read command. When bit 1 is 1, bit 0 selects the in-service register (1) or the pending register (0). Bit 2 = 1 arms a poll. When bit 6 is 1, special mask mode takes the value of bit 5.
- R8: `rd_data` shows the mask register when `addr` is 1, and the selected register when `addr` is 0. An armed poll overrides both.
- R9: While a poll is armed, `rd_data` is 0x80 plus the winning input if `int_req` would be 1, and 0 otherwise. A read strobe clears the poll flag, along with that input's pending and in-service bits.
- R10: `ack_vector` is the vector base ORed with the winner, or with 7 when there is no winner. An `ack` with a winner clears its pending bit. It sets the winner's in-service bit, unless auto-EOI is on; in that case, with rotate-on-auto-EOI, the base becomes winner + 1. An `ack` with no winner changes nothing.
- R11: Operational codes come from bits 7:5 when bits 4 and 3 are 0. Code 1 clears the highest-ranked in-service bit. Code 5 does the same and also sets the base to that input + 1.
- R12: Code 3 clears the in-service bit selected by bits 2:0. Code 7 does the same and sets the base to that input + 1 (mod 8). Code 6 sets the base to bits 2:0 + 1 (mod 8). Code 2 has no effect.
- R13: Codes 0 and 4 set rotate-on-auto-EOI to bit 7 (0 and 1 respectively).
- R14: An address-1 write while idle loads the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request inputs, edge captured |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe (consumes a poll) |
| addr | input | 1 | Port address, 0 or 1 |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for the current address |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector returned on acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| nested_mode | output | 1 | Special fully nested mode flag |
| level_err | output | 1 | Level-triggered mode was requested |

## Verification
A wrong priority base or a wrong in-service bit shows up at the ports in two ways. `int_req` and `ack_vector` change combinationally in the same cycle, and the next poll returns a different code. A misrouted initialization step shows up on the next address-1 write: the value lands in the wrong register, and the following `rd_data` or `ack_vector` sample reveals it. A poll flag that fails to clear is visible on the very next cycle, because `rd_data` keeps showing the poll code instead of the selected register.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;
  localparam int NUM_IN = 8;
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int DW     = 8;
  localparam int VB_W   = DW - IDX_W;

  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_VBASE,
    INIT_CASC,
    INIT_MODE
  } init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_OFF = 3'd0,
    OP_EOI_NS       = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_SP       = 3'd3,
    OP_ROT_AEOI_ON  = 3'd4,
    OP_EOI_NS_ROT   = 3'd5,
    OP_SET_BASE     = 3'd6,
    OP_EOI_SP_ROT   = 3'd7
  } op_e;
endpackage

// File: rtl/pic_rank_find.sv
module pic_rank_find #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [IW:0]   rank
);
  logic [N-1:0] rot;

  // rot[k] is the input that sits k places below the base in priority
  always_comb begin
    for (int k = 0; k < N; k++) begin
      rot[k] = req[IW'(k) + base];
    end
  end

  always_comb begin
    rank = (IW+1)'(N);
    for (int k = N-1; k >= 0; k--) begin
      if (rot[k]) rank = (IW+1)'(k);
    end
    found = |rot;
    idx   = rank[IW-1:0] + base;
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_port_pkg::*;
(
  input  logic [NUM_IN-1:0] irr,
  input  logic [NUM_IN-1:0] imr,
  input  logic [NUM_IN-1:0] isr,
  input  logic [IDX_W-1:0]  base,
  input  logic              spec_mask,
  output logic              has_irq,
  output logic [IDX_W-1:0]  win_idx,
  output logic              isr_any,
  output logic [IDX_W-1:0]  isr_top
);
  logic [NUM_IN-1:0] pend_vec, svc_vec;
  logic              pend_found, svc_found;
  logic [IDX_W-1:0]  svc_idx;
  logic [IDX_W:0]    pend_rank, svc_rank, top_rank;

  assign pend_vec = irr & ~imr;
  assign svc_vec  = spec_mask ? (isr & ~imr) : isr;

  pic_rank_find #(.N(NUM_IN), .IW(IDX_W)) u_pend (
    .req(pend_vec), .base(base), .found(pend_found), .idx(win_idx), .rank(pend_rank)
  );

  pic_rank_find #(.N(NUM_IN), .IW(IDX_W)) u_svc (
    .req(svc_vec), .base(base), .found(svc_found), .idx(svc_idx), .rank(svc_rank)
  );

  pic_rank_find #(.N(NUM_IN), .IW(IDX_W)) u_top (
    .req(isr), .base(base), .found(isr_any), .idx(isr_top), .rank(top_rank)
  );

  assign has_irq = pend_found && (!svc_found || (pend_rank < svc_rank));

  // svc_idx and top_rank are produced for symmetry; fold them into a no-op use
  logic unused_ok;
  assign unused_ok = ^{svc_idx, top_rank};
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     a1_wr,
  input  logic     single,
  input  logic     need4,
  output init_st_e state
);
  init_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = INIT_VBASE;
    end else if (a1_wr) begin
      case (st_q)
        INIT_VBASE: st_d = single ? (need4 ? INIT_MODE : INIT_IDLE) : INIT_CASC;
        INIT_CASC:  st_d = need4 ? INIT_MODE : INIT_IDLE;
        INIT_MODE:  st_d = INIT_IDLE;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= INIT_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R5: the cascade state is only entered from the vector-base state
  a_r5_casc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == INIT_CASC) |-> ($past(st_q) == INIT_VBASE));

  // R6: the mode state is only visited when the mode word was requested
  a_r6_mode_needs4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == INIT_MODE) |-> need4);
endmodule

// File: rtl/pic_prog_port.sv
module pic_prog_port
  import pic_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              ack,
  output logic [DW-1:0]     ack_vector,
  output logic              int_req,
  output logic              nested_mode,
  output logic              level_err
);
  logic [NUM_IN-1:0] irr_q, irr_d, imr_q, imr_d, isr_q, isr_d, last_q;
  logic [IDX_W-1:0]  base_q, base_d;
  logic [VB_W-1:0]   vb_q, vb_d;
  logic rdsel_q, rdsel_d, poll_q, poll_d, smm_q, smm_d;
  logic aeoi_q, aeoi_d, rot_q, rot_d, sfnm_q, sfnm_d;
  logic need4_q, need4_d, single_q, single_d, lerr_q, lerr_d;

  logic             has_irq, isr_any;
  logic [IDX_W-1:0] win_idx, isr_top, sel;
  init_st_e         init_st;
  op_e              op;
  logic             wr_init, wr_rdcmd, wr_op, wr_a1, rd_poll, do_ack;

  assign sel      = wr_data[IDX_W-1:0];
  assign op       = op_e'(wr_data[7:5]);
  assign wr_init  = wr_en && !addr && wr_data[4];
  assign wr_rdcmd = wr_en && !addr && !wr_data[4] && wr_data[3];
  assign wr_op    = wr_en && !addr && !wr_data[4] && !wr_data[3];
  assign wr_a1    = wr_en && addr;
  assign rd_poll  = !wr_en && rd_en && poll_q;
  assign do_ack   = !wr_en && !rd_poll && ack && has_irq;

  pic_resolver u_res (
    .irr(irr_q), .imr(imr_q), .isr(isr_q), .base(base_q), .spec_mask(smm_q),
    .has_irq(has_irq), .win_idx(win_idx), .isr_any(isr_any), .isr_top(isr_top)
  );

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_init), .a1_wr(wr_a1),
    .single(single_q), .need4(need4_q), .state(init_st)
  );

  // next-state process
  always_comb begin
    irr_d    = irr_q | (irq_in & ~last_q);
    imr_d    = imr_q;
    isr_d    = isr_q;
    base_d   = base_q;
    vb_d     = vb_q;
    rdsel_d  = rdsel_q;
    poll_d   = poll_q;
    smm_d    = smm_q;
    aeoi_d   = aeoi_q;
    rot_d    = rot_q;
    sfnm_d   = sfnm_q;
    need4_d  = need4_q;
    single_d = single_q;
    lerr_d   = lerr_q;

    if (wr_init) begin
      irr_d    = '0;
      imr_d    = '0;
      isr_d    = '0;
      base_d   = '0;
      rdsel_d  = 1'b0;
      poll_d   = 1'b0;
      smm_d    = 1'b0;
      aeoi_d   = 1'b0;
      rot_d    = 1'b0;
      sfnm_d   = 1'b0;
      need4_d  = wr_data[0];
      single_d = wr_data[1];
      lerr_d   = wr_data[3];
    end else if (wr_rdcmd) begin
      if (wr_data[1]) rdsel_d = wr_data[0];
      if (wr_data[2]) poll_d  = 1'b1;
      if (wr_data[6]) smm_d   = wr_data[5];
    end else if (wr_op) begin
      case (op)
        OP_ROT_AEOI_OFF, OP_ROT_AEOI_ON: rot_d = wr_data[7];
        OP_EOI_NS: begin
          if (isr_any) isr_d[isr_top] = 1'b0;
        end
        OP_EOI_NS_ROT: begin
          if (isr_any) begin
            isr_d[isr_top] = 1'b0;
            base_d         = isr_top + IDX_W'(1);
          end
        end
        OP_EOI_SP:     isr_d[sel] = 1'b0;
        OP_EOI_SP_ROT: begin
          isr_d[sel] = 1'b0;
          base_d     = sel + IDX_W'(1);
        end
        OP_SET_BASE:   base_d = sel + IDX_W'(1);
        default: ;
      endcase
    end else if (wr_a1) begin
      case (init_st)
        INIT_IDLE:  imr_d = wr_data[NUM_IN-1:0];
        INIT_VBASE: vb_d  = wr_data[DW-1:IDX_W];
        INIT_MODE: begin
          sfnm_d = wr_data[4];
          aeoi_d = wr_data[1];
        end
        default: ;
      endcase
    end else if (rd_poll) begin
      poll_d = 1'b0;
      if (has_irq) begin
        irr_d[win_idx] = 1'b0;
        isr_d[win_idx] = 1'b0;
      end
    end else if (do_ack) begin
      irr_d[win_idx] = 1'b0;
      if (aeoi_q) begin
        if (rot_q) base_d = win_idx + IDX_W'(1);
      end else begin
        isr_d[win_idx] = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0; imr_q <= '0; isr_q <= '0; last_q <= '0;
      base_q <= '0; vb_q <= '0;
      rdsel_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0;
      aeoi_q <= 1'b0; rot_q <= 1'b0; sfnm_q <= 1'b0;
      need4_q <= 1'b0; single_q <= 1'b0; lerr_q <= 1'b0;
    end else begin
      irr_q <= irr_d; imr_q <= imr_d; isr_q <= isr_d; last_q <= irq_in;
      base_q <= base_d; vb_q <= vb_d;
      rdsel_q <= rdsel_d; poll_q <= poll_d; smm_q <= smm_d;
      aeoi_q <= aeoi_d; rot_q <= rot_d; sfnm_q <= sfnm_d;
      need4_q <= need4_d; single_q <= single_d; lerr_q <= lerr_d;
    end
  end

  always_comb begin
    if (poll_q)       rd_data = has_irq ? {1'b1, {(DW-1-IDX_W){1'b0}}, win_idx} : '0;
    else if (addr)    rd_data = imr_q;
    else if (rdsel_q) rd_data = isr_q;
    else              rd_data = irr_q;
  end

  assign ack_vector  = {vb_q, has_irq ? win_idx : {IDX_W{1'b1}}};
  assign int_req     = has_irq;
  assign nested_mode = sfnm_q;
  assign level_err   = lerr_q;

  // R3: a request always has an unmasked pending input behind it
  a_r3_req_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> |(irr_q & ~imr_q));

  // R4: the initialization word wipes the three interrupt registers
  a_r4_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[4]) |=> (irr_q == '0 && isr_q == '0 && imr_q == '0));

  // R9: a poll is consumed by a single read
  a_r9_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll_q) |=> !poll_q);

  // R10: an acknowledged request without auto-EOI lands in service
  a_r10_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && !rd_en && int_req && !aeoi_q) |=> (isr_q != '0));
endmodule

// File: tb/pic_prog_port_tb.sv
module pic_prog_port_tb;
  logic       clk, rst_n;
  logic [7:0] r_irq, r_d;
  logic       r_wr, r_rd, r_addr, r_ack;
  logic [7:0] rd_data, ack_vector;
  logic       int_req, nested_mode, level_err;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_irr, m_imr, m_isr, m_last, m_base, m_vb, m_sel, m_poll, m_smm;
  int m_aeoi, m_rot, m_sfnm, m_need4, m_single, m_err, m_st;

  pic_prog_port u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(r_irq), .wr_en(r_wr), .rd_en(r_rd),
    .addr(r_addr), .wr_data(r_d), .rd_data(rd_data), .ack(r_ack),
    .ack_vector(ack_vector), .int_req(int_req), .nested_mode(nested_mode),
    .level_err(level_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int rk(int v, int b);
    for (int k = 0; k < 8; k++) if (((v >> ((k + b) % 8)) & 1) != 0) return k;
    return 8;
  endfunction

  function automatic int winner();
    int p, s;
    p = rk(m_irr & ~m_imr & 255, m_base);
    s = rk(m_smm != 0 ? (m_isr & ~m_imr & 255) : m_isr, m_base);
    if (p < 8 && p < s) return (p + m_base) % 8;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_irr = 0; m_imr = 0; m_isr = 0; m_last = 0; m_base = 0; m_vb = 0; m_sel = 0;
    m_poll = 0; m_smm = 0; m_aeoi = 0; m_rot = 0; m_sfnm = 0; m_need4 = 0;
    m_single = 0; m_err = 0; m_st = 0;
  endtask

  task automatic mdl_step();
    int w, nirr, d, t;
    w = winner();
    d = int'(r_d);
    nirr = m_irr | (int'(r_irq) & ~m_last & 255);
    m_last = int'(r_irq);
    if (r_wr && !r_addr && d[4]) begin
      nirr = 0; m_imr = 0; m_isr = 0; m_base = 0; m_sel = 0; m_poll = 0; m_smm = 0;
      m_aeoi = 0; m_rot = 0; m_sfnm = 0; m_need4 = d & 1; m_single = (d >> 1) & 1;
      m_err = (d >> 3) & 1; m_st = 1;
    end else if (r_wr && !r_addr && d[3]) begin
      if (d[1]) m_sel = d & 1;
      if (d[2]) m_poll = 1;
      if (d[6]) m_smm = (d >> 5) & 1;
    end else if (r_wr && !r_addr) begin
      case (d >> 5)
        0, 4: m_rot = d >> 7;
        1, 5: begin
          t = rk(m_isr, m_base);
          if (t < 8) begin
            t = (t + m_base) % 8;
            m_isr &= ~(1 << t);
            if ((d >> 5) == 5) m_base = (t + 1) % 8;
          end
        end
        3, 7: begin
          m_isr &= ~(1 << (d & 7));
          if ((d >> 5) == 7) m_base = ((d & 7) + 1) % 8;
        end
        6: m_base = ((d & 7) + 1) % 8;
        default: ;
      endcase
    end else if (r_wr) begin
      case (m_st)
        0: m_imr = d;
        1: begin m_vb = d & 248; m_st = (m_single != 0) ? ((m_need4 != 0) ? 3 : 0) : 2; end
        2: m_st = (m_need4 != 0) ? 3 : 0;
        default: begin m_sfnm = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_st = 0; end
      endcase
    end else if (r_rd && m_poll != 0) begin
      m_poll = 0;
      if (w >= 0) begin nirr &= ~(1 << w); m_isr &= ~(1 << w); end
    end else if (r_ack && w >= 0) begin
      nirr &= ~(1 << w);
      if (m_aeoi != 0) begin
        if (m_rot != 0) m_base = (w + 1) % 8;
      end else m_isr |= (1 << w);
    end
    m_irr = nirr;
  endtask

  task automatic compare();
    int w, er;
    w = winner();
    if (m_poll != 0) er = (w >= 0) ? 128 + w : 0;
    else if (r_addr) er = m_imr;
    else er = (m_sel != 0) ? m_isr : m_irr;
    chk({cur_req, " rd_data"}, int'(rd_data), er);
    chk({cur_req, " ack_vector"}, int'(ack_vector), m_vb + ((w >= 0) ? w : 7));
    chk({cur_req, " int_req"}, int'(int_req), (w >= 0) ? 1 : 0);
    chk({cur_req, " nested_mode"}, int'(nested_mode), m_sfnm);
    chk({cur_req, " level_err"}, int'(level_err), m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) mdl_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    r_wr = 1'b1; r_addr = a; r_d = d;
    tick();
    r_wr = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    r_rd = 1'b1; r_addr = a;
    #1 v = int'(rd_data);
    tick();
    r_rd = 1'b0;
  endtask

  task automatic do_ack(output int v);
    r_ack = 1'b1;
    #1 v = int'(ack_vector);
    tick();
    r_ack = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m);
    r_irq = r_irq | m;
    tick();
    r_irq = r_irq & ~m;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    mdl_reset();
    rst_n = 1'b0; r_irq = '0; r_d = '0; r_wr = 1'b0; r_rd = 1'b0; r_addr = 1'b0; r_ack = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    cur_req = "R1";
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset int_req", int'(int_req), 0);

    // R4 / R5 / R6: cascaded init with mode word
    cur_req = "R4"; wr(1'b0, 8'h11);
    cur_req = "R5"; wr(1'b1, 8'h47); wr(1'b1, 8'h00);
    cur_req = "R6"; wr(1'b1, 8'h10); tick();
    chk("R6 nested_mode", int'(nested_mode), 1);

    // R2 / R10: two edges, acknowledge the higher-ranked one
    cur_req = "R2"; pulse(8'h28);
    cur_req = "R10"; do_ack(v);
    chk("R10 ack vector", v, 8'h43);
    cur_req = "R7"; wr(1'b0, 8'h0B); tick();
    chk("R7 isr read", int'(rd_data), 8'h08);
    cur_req = "R3"; tick();
    chk("R3 lower rank blocked", int'(int_req), 0);

    cur_req = "R11"; wr(1'b0, 8'h20); tick();
    cur_req = "R14"; wr(1'b1, 8'h20); r_addr = 1'b1; tick();
    cur_req = "R8"; rd(1'b1, v);
    chk("R8 mask read", v, 8'h20);
    wr(1'b1, 8'h00);

    cur_req = "R9"; wr(1'b0, 8'h0C); rd(1'b0, v);
    chk("R9 poll code", v, 8'h85);
    rd(1'b0, v);
    chk("R9 poll consumed", v, 0);

    // R12: rotation and specific EOIs
    cur_req = "R12"; wr(1'b0, 8'hC4); pulse(8'h44);
    wr(1'b0, 8'h0C); rd(1'b0, v);
    chk("R12 rotated poll", v, 8'h86);
    do_ack(v); wr(1'b0, 8'h62); tick();
    pulse(8'h02); do_ack(v); wr(1'b0, 8'hE1); tick();
    cur_req = "R11"; pulse(8'h10); do_ack(v); wr(1'b0, 8'hA0); tick();
    cur_req = "R12"; wr(1'b0, 8'h40); tick();

    // R3 / R7: special mask mode
    cur_req = "R3"; wr(1'b0, 8'hC7); pulse(8'h02); do_ack(v);
    pulse(8'h08); tick();
    cur_req = "R7"; wr(1'b1, 8'h02); wr(1'b0, 8'h68); tick();
    chk("R7 special mask lets lower rank through", int'(int_req), 1);

    // R13 / R10: auto-EOI with rotation, single mode
    cur_req = "R4"; wr(1'b0, 8'h13);
    cur_req = "R5"; wr(1'b1, 8'h80);
    cur_req = "R6"; wr(1'b1, 8'h02);
    cur_req = "R13"; wr(1'b0, 8'h80); pulse(8'h04);
    cur_req = "R10"; do_ack(v);
    chk("R10 auto-EOI vector", v, 8'h82);
    cur_req = "R13"; pulse(8'h0C); wr(1'b0, 8'h0C); rd(1'b0, v);
    chk("R13 base moved past 2", v, 8'h83);
    wr(1'b0, 8'h00); tick();

    // R4: level request flagged, single without mode word
    cur_req = "R4"; wr(1'b0, 8'h1A); tick();
    chk("R4 level_err", int'(level_err), 1);
    cur_req = "R5"; wr(1'b1, 8'h20);
    cur_req = "R14"; wr(1'b1, 8'hFF); tick();
    cur_req = "R10"; do_ack(v);
    chk("R10 spurious vector", v, 8'h27);

    // R2: held level captured once
    cur_req = "R2"; wr(1'b1, 8'h00);
    r_irq = 8'h01; tick(); tick();
    wr(1'b0, 8'h0C); rd(1'b0, v);
    chk("R2 held input polled", v, 8'h80);
    tick(); tick();
    chk("R2 no re-capture", int'(int_req), 0);
    r_irq = 8'h00; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule